// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in an SDRAM controller beside the command sequencer. When a read or write command is issued, the sequencer pulses `start` with the starting column and the current mode settings. From the next cycle on, the block presents one column address per clock. With each address it drives a valid flag, and it marks the final beat of the burst. The data path and the CAS-latency alignment are outside this block; it only produces the order in which columns are visited.

The block supports four fixed burst lengths: 1, 2, 4 and 8 beats. A fixed burst stays inside the aligned block of its own size. Within that block it runs either in counting order or in XOR order. A full-page burst always counts upward through the whole column range, wraps at the top, and ends only when `terminate` or a new `start` arrives. A single-write setting shortens every write to one beat and leaves reads at the programmed length. The mode is captured when a burst starts, so changes on the mode inputs during a burst have no effect on it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `col_valid` and `col_last` are 0.
- R2: A `start` sampled on a clock edge makes `col_valid` 1 and `col` equal to the sampled `start_col` from that edge onward. This first beat is beat 0.
- R3: `bl_code` selects the burst length. Code 0 gives 1 beat, code 1 gives 2, code 2 gives 4, code 3 gives 8, and code 7 selects full page. The reserved codes 4, 5 and 6 behave as 1 beat.
- R4: When `intlv_order` is 0 and the length is fixed at 2^L, beat n carries `start_col` with its low L bits replaced by (`start_col` + n) mod 2^L. Start 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R5: When `intlv_order` is 1 and the length is fixed at 2^L, beat n carries `start_col` with its low L bits replaced by the low L bits of (`start_col` XOR n). Start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R6: A fixed burst keeps `col_valid` at 1 for exactly its length in beats. `col_last` is 1 only on the final beat. In the cycle after the final beat, `col_valid` is 0 unless a new `start` was sampled.
- R7: In full-page mode, beat n is (`start_col` + n) mod 2^COL_W whatever `intlv_order` is. `col_last` stays 0, and the burst continues until it is terminated or restarted.
- R8: When `single_write` and `is_write` are both 1 at `start`, the burst is one beat with `col_last` 1, whatever `bl_code` holds. With `is_write` 0, the programmed length applies.
- R9: A `terminate` sampled without `start` makes `col_valid` and `col_last` 0 from that edge onward.
- R10: A `start` sampled during a burst abandons the old burst and begins beat 0 of the new one on that edge. When `start` and `terminate` are sampled together, `start` wins.
- R11: `bl_code`, `intlv_order`, `single_write` and `is_write` are captured only when `start` is sampled. Changes on them during a burst do not change its addresses or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W | Starting column address |
| is_write | input | 1 | The starting command is a write |
| bl_code | input | 3 | Burst length code (see R3) |
| intlv_order | input | 1 | 0 = counting order, 1 = XOR order |
| single_write | input | 1 | Limit writes to one beat |
| terminate | input | 1 | Stop the running burst |
| col | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | `col` holds a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
Every output comes from registers loaded on the edge that samples the inputs. Beat n of a burst therefore appears right after the (n+1)-th rising edge, counting from the edge that samples `start`. A `terminate` or restart shows on the edge that samples it. The bench drives inputs on falling edges and checks each result at the next falling edge, which is half a cycle after the edge that produced it. It counts the beats one falling edge per cycle, so every expected address lands on the cycle it is due.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Decoded burst settings, captured at the start of a burst
  typedef struct packed {
    logic [1:0] len_log;   // fixed length is 2**len_log beats
    logic       full;      // full-page: runs until stopped
    logic       intlv;     // XOR order
  } burst_cfg_t;

  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_PAGE = 3'd7;

endpackage

// File: rtl/colgen_mode_decode.sv
module colgen_mode_decode
  import colgen_pkg::*;
(
  input  logic [2:0] bl_code,
  input  logic       intlv_order,
  input  logic       single_write,
  input  logic       is_write,
  output burst_cfg_t cfg
);

  always_comb begin
    cfg = '0;
    unique case (bl_code)
      BLC_2:    cfg.len_log = 2'd1;
      BLC_4:    cfg.len_log = 2'd2;
      BLC_8:    cfg.len_log = 2'd3;
      BLC_PAGE: cfg.full    = 1'b1;
      default:  cfg.len_log = 2'd0;   // code 0 and reserved codes
    endcase
    // XOR order has no meaning across a whole page
    cfg.intlv = intlv_order && !cfg.full;
    if (single_write && is_write) begin
      cfg.len_log = 2'd0;
      cfg.full    = 1'b0;
      cfg.intlv   = 1'b0;
    end
  end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
  import colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             stop,
  input  burst_cfg_t       load_cfg,
  input  burst_cfg_t       cur_cfg,
  output logic             busy,
  output logic             last,
  output logic [COL_W-1:0] idx
);

  logic [COL_W-1:0] idx_nx;
  logic [COL_W-1:0] final_idx;

  assign idx_nx    = idx + COL_W'(1);
  assign final_idx = (COL_W'(1) << cur_cfg.len_log) - COL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      last <= 1'b0;
      idx  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      last <= !load_cfg.full && (load_cfg.len_log == 2'd0);
      idx  <= '0;
    end else if (stop || last || !busy) begin
      busy <= 1'b0;
      last <= 1'b0;
      idx  <= '0;
    end else begin
      idx  <= idx_nx;
      last <= !cur_cfg.full && (idx_nx == final_idx);
    end
  end

  // R7
  page_never_last_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_cfg.full && !$past(load)) |-> !last);

  // R6
  beat_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && !load && !stop) |=> (busy && idx == $past(idx) + COL_W'(1)));

endmodule

// File: rtl/colgen_addr_gen.sv
module colgen_addr_gen
  import colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] offs;
  logic [COL_W-1:0] linear;

  assign linear    = base + idx;
  assign wrap_mask = (COL_W'(1) << cfg.len_log) - COL_W'(1);
  assign offs      = cfg.intlv ? (base ^ idx) : linear;

  always_comb begin
    if (cfg.full) col = linear;
    else          col = (base & ~wrap_mask) | (offs & wrap_mask);
  end

  // R4
  always_comb begin
    if (!cfg.full && (idx & ~wrap_mask) == '0)
      block_stay_chk: assert ((col & ~wrap_mask) == (base & ~wrap_mask));
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_write,
  input  logic [2:0]       bl_code,
  input  logic             intlv_order,
  input  logic             single_write,
  input  logic             terminate,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last
);

  burst_cfg_t       cfg_in;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_idx;

  colgen_mode_decode u_dec (
    .bl_code      (bl_code),
    .intlv_order  (intlv_order),
    .single_write (single_write),
    .is_write     (is_write),
    .cfg          (cfg_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      cfg_q  <= cfg_in;
      base_q <= start_col;
    end
  end

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .stop     (terminate),
    .load_cfg (cfg_in),
    .cur_cfg  (cfg_q),
    .busy     (col_valid),
    .last     (col_last),
    .idx      (beat_idx)
  );

  colgen_addr_gen #(.COL_W(COL_W)) u_addr (
    .base (base_q),
    .idx  (beat_idx),
    .cfg  (cfg_q),
    .col  (col)
  );

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_valid && col == $past(start_col)));

  // R9
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (terminate && !start) |=> (!col_valid && !col_last));

  // R6
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  // R6
  end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (col_last && !start) |=> !col_valid);

endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

  localparam int COL_W   = 11;
  localparam int CLK_PER = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             is_write = 1'b0;
  logic [2:0]       bl_code = '0;
  logic             intlv_order = 1'b0;
  logic             single_write = 1'b0;
  logic             terminate = 1'b0;
  logic [COL_W-1:0] col;
  logic             col_valid;
  logic             col_last;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PER/2) clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) uut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .is_write(is_write), .bl_code(bl_code), .intlv_order(intlv_order),
    .single_write(single_write), .terminate(terminate),
    .col(col), .col_valid(col_valid), .col_last(col_last)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: act=%0d exp<100000 cycles", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Length in beats from R3/R8; 0 means full page
  function automatic int beats_of(int code, bit wr, bit sw);
    if (sw && wr) return 1;
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int s, int n, int len, bit il);
    int m;
    if (len == 0) return (s + n) % (1 << COL_W);
    m = len - 1;
    if (il) return (s & ~m) | ((s ^ n) & m);
    return (s & ~m) | ((s + n) & m);
  endfunction

  // Run a full fixed-length burst; mode inputs are scrambled mid-burst (R11)
  task automatic run_burst(int s, int code, bit il, bit wr, bit sw, string tag);
    int len = beats_of(code, wr, sw);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(s); bl_code = 3'(code);
    intlv_order = il; is_write = wr; single_write = sw;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        start = 1'b0;
        bl_code = 3'(~code); intlv_order = ~il; is_write = ~wr; single_write = ~sw;
        start_col = COL_W'(s + 7);
      end
      chk({tag, " col"},   int'(col), exp_col(s, i, len, il && (len != 0)));
      chk({tag, " valid"}, int'(col_valid), 1);
      chk({tag, " last"},  int'(col_last), (i == len - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk({tag, " end"}, int'(col_valid), 0);
  endtask

  initial begin
    // R1
    @(negedge clk); @(negedge clk);
    chk("R1 valid in reset", int'(col_valid), 0);
    chk("R1 last in reset", int'(col_last), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(col_valid), 0);

    // R4 / R5 / R6 / R2 / R11: sweep start columns, lengths and orders
    for (int s = 0; s < 24; s++)
      for (int c = 0; c < 4; c++) begin
        run_burst(s, c, 1'b0, 1'b0, 1'b0, "R4 R6 seq");
        run_burst(s, c, 1'b1, 1'b0, 1'b0, "R5 R6 xor");
      end
    run_burst(2045, 3, 1'b0, 1'b0, 1'b0, "R4 top block");
    run_burst(2043, 3, 1'b1, 1'b1, 1'b0, "R5 top block");

    // R3 reserved codes act as one beat
    for (int c = 4; c < 7; c++) run_burst(100 + c, c, 1'b0, 1'b0, 1'b0, "R3 reserved");

    // R8 single write vs read
    run_burst(13, 3, 1'b0, 1'b1, 1'b1, "R8 single write");
    run_burst(13, 3, 1'b0, 1'b0, 1'b1, "R8 read keeps length");
    run_burst(13, 7, 1'b0, 1'b1, 1'b1, "R8 single write over page");

    // R7 full page wraps at the top, ignores XOR order, never last
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(2044); bl_code = 3'd7; intlv_order = 1'b1;
    is_write = 1'b0; single_write = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      start = 1'b0; bl_code = 3'd0;
      chk("R7 page col", int'(col), (2044 + i) % 2048);
      chk("R7 page valid", int'(col_valid), 1);
      chk("R7 page last", int'(col_last), 0);
    end
    // R9 terminate
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    chk("R9 terminate valid", int'(col_valid), 0);
    chk("R9 terminate last", int'(col_last), 0);
    @(negedge clk);
    chk("R9 stays idle", int'(col_valid), 0);

    // R10 restart mid-burst
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(3); bl_code = 3'd3; intlv_order = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R10 first burst", int'(col), exp_col(3, i, 8, 1'b0));
    end
    start = 1'b1; start_col = COL_W'(22); bl_code = 3'd2; intlv_order = 1'b1;
    terminate = 1'b1;   // start wins over terminate
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      start = 1'b0; terminate = 1'b0;
      chk("R10 restart col", int'(col), exp_col(22, i, 4, 1'b1));
      chk("R10 restart valid", int'(col_valid), 1);
      chk("R10 restart last", int'(col_last), (i == 3) ? 1 : 0);
    end
    @(negedge clk);
    chk("R10 restart end", int'(col_valid), 0);

    // R9 terminate of an idle block has no effect
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    chk("R9 idle terminate", int'(col_valid), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule